// File: doc/BRIEF.md
# Burst Column Address Generator

This block holds the operating mode word of a double data rate memory device and, from it, produces the column address for every beat of one read or write burst. A controller writes the mode word with a load strobe. The strobe carries a 12-bit operand and two register-select bits. From the operand the block decodes the burst length, the address ordering, the read latency, and the test and delay-locked-loop reset flags. A second register target carries only the delay-locked-loop enable bit.

A burst begins with a single-cycle start strobe that carries the first column address. On the cycles that follow, the block presents one column address per cycle, together with a valid flag and a flag that marks the final beat. The changing low bits wrap inside an aligned block whose size is the burst length. They follow one of two orders, chosen by a mode bit: a wrapping count, or the start value XORed with the beat number. The bits above the block stay fixed for the whole burst. If an operand carries a reserved length or latency code, the block raises an error flag and keeps its previous settings.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the block reports burst length 2, sequential order, read latency 3, DLL enabled, test mode off, DLL reset off, error flag clear, and no valid column.
- R2: A load with select bit 0 low writes the main register, and the new values appear in the cycle after the load. Operand [2:0] gives the length: 001 gives 2, 010 gives 4 and 011 gives 8. Bit 3 gives the order: 0 is sequential and 1 is interleaved. Operand [6:4] gives the read latency: 011 gives 3 and 100 gives 4. Bit 7 drives the test-mode output and bit 8 drives the DLL-reset output. Bits 11:9 have no effect.
- R3: A main load whose length code or latency code is reserved sets the error flag and leaves every main field unchanged. A later main load with valid codes clears the flag.
- R4: A load with select bits 01 (bit 1 low, bit 0 high) sets the DLL-enable output to the inverse of operand bit 0. It touches no other output. A load with select bits 11 changes nothing.
- R5: In the cycle after a start strobe, the valid flag is high and the column output equals the start column. The following beats appear on consecutive cycles, for a total equal to the burst length.
- R6: Column bits above the low log2(length) bits equal the start column on every beat.
- R7: In sequential order the low bits of beat i are (start + i) modulo the length.
- R8: In interleaved order the low bits of beat i are the low start bits XOR i.
- R9: The last-beat flag is high only on beat (length-1) of a valid burst. In the cycle after that beat the valid flag is low, unless a new start strobe was given.
- R10: A start strobe during a burst restarts the sequence at beat 0 with the new start column. The sequence uses the register settings at the time of the new strobe.
- R11: A running burst keeps the length and order that were in force at its start strobe, even if the main register is written during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeLoad | input | 1 | Register write strobe |
| modeOp | input | 12 | Operand written by the strobe |
| modeSel | input | 2 | Register select bits |
| burstStart | input | 1 | Single-cycle burst start |
| startCol | input | 8 | First column of the burst |
| colOut | output | 8 | Column for the current beat |
| colValid | output | 1 | A beat is being presented |
| lastBeat | output | 1 | Current beat is the final one |
| burstLen | output | 4 | Decoded burst length (2, 4 or 8) |
| interleaved | output | 1 | 1 when interleaved order is selected |
| readLat | output | 3 | Decoded read latency (3 or 4) |
| testMode | output | 1 | Test-mode bit of the main register |
| dllReset | output | 1 | DLL-reset bit of the main register |
| dllEnable | output | 1 | DLL enable from the extended register |
| cfgError | output | 1 | Last main load carried a reserved code |

## Verification
A corrupted beat counter or latched length shows up at once on colOut, because the low bits leave the expected sequential or XOR order on the very next beat. The same fault also moves lastBeat and the cycle in which colValid drops, within at most eight cycles of the start strobe. A wrong decode or write enable in the mode register appears on the decoded field outputs in the cycle after the load. It then changes the length or order of every later burst. These two effects are compared against an independent model after each load and on every beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // strobes from the burst control to the address datapath
  typedef struct packed {
    logic capture;   // take a new start column, beat 0
    logic advance;   // move to the next beat
  } beatStrobe_t;

  localparam int BEAT_W = 3;  // enough for a beat index up to 7
endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg #(
  parameter int OP_W  = 12,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [OP_W-1:0]  modeOp,
  input  logic [SEL_W-1:0] modeSel,
  output logic [1:0]       lenLog,
  output logic             ilvMode,
  output logic             latFour,
  output logic             testMode,
  output logic             dllReset,
  output logic             dllEnable,
  output logic             cfgError
);
  logic lenOk, latOk, mainWr, extWr;

  always_comb begin
    lenOk  = (modeOp[2:0] == 3'b001) || (modeOp[2:0] == 3'b010) ||
             (modeOp[2:0] == 3'b011);
    latOk  = (modeOp[6:4] == 3'b011) || (modeOp[6:4] == 3'b100);
    mainWr = modeLoad && !modeSel[0];
    extWr  = modeLoad && modeSel[0] && !modeSel[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenLog    <= 2'd1;
      ilvMode   <= 1'b0;
      latFour   <= 1'b0;
      testMode  <= 1'b0;
      dllReset  <= 1'b0;
      dllEnable <= 1'b1;
      cfgError  <= 1'b0;
    end else begin
      if (mainWr) begin
        if (lenOk && latOk) begin
          lenLog   <= modeOp[1:0];
          ilvMode  <= modeOp[3];
          latFour  <= modeOp[6];
          testMode <= modeOp[7];
          dllReset <= modeOp[8];
          cfgError <= 1'b0;
        end else begin
          cfgError <= 1'b1;
        end
      end
      if (extWr) dllEnable <= !modeOp[0];
    end
  end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        burstStart,
  input  logic        beatIsLast,
  output beatStrobe_t strobe,
  output logic        active
);
  always_comb begin
    strobe.capture = burstStart;
    strobe.advance = active && !burstStart && !beatIsLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) active <= 1'b0;
    else       active <= burstStart || (active && !beatIsLast);
  end
endmodule

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  beatStrobe_t      strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenLogIn,
  input  logic             ilvIn,
  output logic [COL_W-1:0] colOut,
  output logic             beatIsLast
);
  logic [COL_W-1:0]  baseCol;
  logic [BEAT_W-1:0] beatIdx;
  logic [1:0]        lenLog;
  logic              ilv;
  logic [BEAT_W-1:0] lowSeq, lowIlv, lowSel, lastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      beatIdx <= '0;
      lenLog  <= 2'd1;
      ilv     <= 1'b0;
    end else if (strobe.capture) begin
      baseCol <= startCol;
      beatIdx <= '0;
      lenLog  <= lenLogIn;
      ilv     <= ilvIn;
    end else if (strobe.advance) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  always_comb begin
    lowSeq  = baseCol[BEAT_W-1:0] + beatIdx;
    lowIlv  = baseCol[BEAT_W-1:0] ^ beatIdx;
    lowSel  = ilv ? lowIlv : lowSeq;
    lastIdx = BEAT_W'((1 << lenLog) - 1);
    beatIsLast = (beatIdx == lastIdx);
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_col
    if (b < BEAT_W) begin : g_low
      assign colOut[b] = (lenLog > 2'(b)) ? lowSel[b] : baseCol[b];
    end else begin : g_high
      assign colOut[b] = baseCol[b];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int OP_W  = 12,
  parameter int SEL_W = 2,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [OP_W-1:0]  modeOp,
  input  logic [SEL_W-1:0] modeSel,
  input  logic             burstStart,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat,
  output logic [3:0]       burstLen,
  output logic             interleaved,
  output logic [2:0]       readLat,
  output logic             testMode,
  output logic             dllReset,
  output logic             dllEnable,
  output logic             cfgError
);
  logic [1:0]  lenLog;
  logic        latFour, active, beatIsLast;
  beatStrobe_t strobe;

  bcg_mode_reg #(.OP_W(OP_W), .SEL_W(SEL_W)) u_mode (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeOp(modeOp),
    .modeSel(modeSel), .lenLog(lenLog), .ilvMode(interleaved),
    .latFour(latFour), .testMode(testMode), .dllReset(dllReset),
    .dllEnable(dllEnable), .cfgError(cfgError)
  );

  bcg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .burstStart(burstStart),
    .beatIsLast(beatIsLast), .strobe(strobe), .active(active)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .lenLogIn(lenLog), .ilvIn(interleaved), .colOut(colOut),
    .beatIsLast(beatIsLast)
  );

  assign colValid = active;
  assign lastBeat = active && beatIsLast;
  assign burstLen = 4'(1 << lenLog);
  assign readLat  = latFour ? 3'd4 : 3'd3;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int OP_W  = 12,
  parameter int SEL_W = 2,
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeLoad,
  input logic [OP_W-1:0]  modeOp,
  input logic [SEL_W-1:0] modeSel,
  input logic             burstStart,
  input logic [COL_W-1:0] startCol,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat,
  input logic [3:0]       burstLen,
  input logic [2:0]       readLat,
  input logic             cfgError
);
  a_r5_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> colValid && colOut == $past(startCol));

  a_r6_high_fixed: assert property (@(posedge clk) disable iff (!rstN)
    colValid && !burstStart |=> !colValid || colOut[COL_W-1:3] == $past(colOut[COL_W-1:3]));

  a_r9_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && !burstStart |=> !colValid);

  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(burstLen) && burstLen[3:1] != 3'b000);

  a_r2_lat_legal: assert property (@(posedge clk) disable iff (!rstN)
    readLat == 3'd3 || readLat == 3'd4);

  a_r3_reserved_holds: assert property (@(posedge clk) disable iff (!rstN)
    modeLoad && !modeSel[0] && (modeOp[2:0] == 3'b000 || modeOp[2:0] > 3'b011)
    |=> cfgError && $stable(burstLen) && $stable(readLat));
endmodule

bind burst_col_gen bcg_checker #(.OP_W(OP_W), .SEL_W(SEL_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeOp(modeOp),
  .modeSel(modeSel), .burstStart(burstStart), .startCol(startCol),
  .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat),
  .burstLen(burstLen), .readLat(readLat), .cfgError(cfgError)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeLoad = 1'b0;
  logic [11:0] modeOp = '0;
  logic [1:0]  modeSel = '0;
  logic        burstStart = 1'b0;
  logic [7:0]  startCol = '0;
  logic [7:0]  colOut;
  logic        colValid, lastBeat, interleaved, testMode, dllReset, dllEnable, cfgError;
  logic [3:0]  burstLen;
  logic [2:0]  readLat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model of the mode state
  int mLen = 2;
  bit mIlv = 0;
  int mLat = 3;
  bit mTest = 0, mDllR = 0, mDll = 1, mErr = 0;

  always #5 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeOp(modeOp),
    .modeSel(modeSel), .burstStart(burstStart), .startCol(startCol),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat),
    .burstLen(burstLen), .interleaved(interleaved), .readLat(readLat),
    .testMode(testMode), .dllReset(dllReset), .dllEnable(dllEnable),
    .cfgError(cfgError)
  );

  function automatic logic [7:0] expCol(logic [7:0] s, int len, bit ilv, int i);
    logic [7:0] mask, low;
    mask = 8'(len - 1);
    low  = ilv ? (s ^ 8'(i)) : (s + 8'(i));
    return (s & ~mask) | (low & mask);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkMode(string req);
    check(burstLen == 4'(mLen), req, "burstLen", burstLen, mLen);
    check(interleaved == mIlv, req, "interleaved", interleaved, mIlv);
    check(readLat == 3'(mLat), req, "readLat", readLat, mLat);
    check(testMode == mTest, req, "testMode", testMode, mTest);
    check(dllReset == mDllR, req, "dllReset", dllReset, mDllR);
    check(dllEnable == mDll, req, "dllEnable", dllEnable, mDll);
    check(cfgError == mErr, req, "cfgError", cfgError, mErr);
  endtask

  task automatic modelLoad(logic [11:0] op, logic [1:0] sel);
    bit lenOk, latOk;
    if (!sel[0]) begin
      lenOk = op[2:0] inside {3'b001, 3'b010, 3'b011};
      latOk = op[6:4] inside {3'b011, 3'b100};
      if (lenOk && latOk) begin
        mLen = 1 << op[1:0]; mIlv = op[3]; mLat = op[6] ? 4 : 3;
        mTest = op[7]; mDllR = op[8]; mErr = 0;
      end else mErr = 1;
    end else if (!sel[1]) mDll = !op[0];
  endtask

  task automatic doLoad(logic [11:0] op, logic [1:0] sel, string req);
    @(negedge clk);
    modeLoad = 1'b1; modeOp = op; modeSel = sel;
    @(posedge clk); #1;
    modeLoad = 1'b0;
    modelLoad(op, sel);
    checkMode(req);
  endtask

  // full burst with the model settings captured at the start strobe
  task automatic doBurst(logic [7:0] s, string req);
    int len; bit ilv;
    len = mLen; ilv = mIlv;
    @(negedge clk);
    burstStart = 1'b1; startCol = s;
    @(posedge clk); #1;
    burstStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      check(colValid == 1'b1, req, "colValid", colValid, 1);
      check(colOut == expCol(s, len, ilv, i), req, "colOut", colOut, expCol(s, len, ilv, i));
      check(lastBeat == (i == len - 1), "R9", "lastBeat", lastBeat, int'(i == len - 1));
    end
    @(posedge clk); #1;
    check(colValid == 1'b0, "R9", "colValid after last", colValid, 0);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset values
    checkMode("R1");
    check(colValid == 1'b0, "R1", "colValid", colValid, 0);

    // R5 R7 default length 2 burst
    doBurst(8'h37, "R5");
    // R2 length 8 sequential, latency 4, test and dll reset bits, high bits ignored
    doLoad(12'hE_C3 | 12'h180, 2'b00, "R2");
    doBurst(8'hA5, "R7");
    // R8 interleaved length 8 start 5
    doLoad(12'h03B, 2'b00, "R2");
    doBurst(8'h45, "R8");
    doLoad(12'h03A, 2'b10, "R2");
    doBurst(8'hF3, "R6");
    // R3 reserved length and latency codes
    doLoad(12'h034, 2'b00, "R3");
    doLoad(12'h052, 2'b00, "R3");
    doBurst(8'h1E, "R3");
    doLoad(12'h031, 2'b00, "R3");
    // R4 extended register and ignored select 11
    doLoad(12'hFFF, 2'b01, "R4");
    doLoad(12'h000, 2'b11, "R4");
    doLoad(12'h000, 2'b01, "R4");
    doLoad(12'h001, 2'b11, "R4");

    // R10 restart during a length 4 sequential burst
    doLoad(12'h032, 2'b00, "R10");
    @(negedge clk); burstStart = 1'b1; startCol = 8'h21;
    @(posedge clk); #1; burstStart = 1'b0;
    check(colOut == 8'h21, "R10", "beat0", colOut, 8'h21);
    @(negedge clk); burstStart = 1'b1; startCol = 8'h56;
    @(posedge clk); #1; burstStart = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      check(colOut == expCol(8'h56, 4, 0, i), "R10", "colOut", colOut, expCol(8'h56, 4, 0, i));
      check(lastBeat == (i == 3), "R10", "lastBeat", lastBeat, int'(i == 3));
    end
    @(posedge clk); #1;
    check(colValid == 1'b0, "R10", "colValid", colValid, 0);

    // R11 main load during a length 8 sequential burst
    doLoad(12'h033, 2'b00, "R11");
    @(negedge clk); burstStart = 1'b1; startCol = 8'h9A;
    @(posedge clk); #1; burstStart = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      if (i == 2) begin
        modeLoad = 1'b1; modeOp = 12'h039; modeSel = 2'b00;
      end
      if (i == 3) begin
        modeLoad = 1'b0; modelLoad(12'h039, 2'b00);
      end
      check(colOut == expCol(8'h9A, 8, 0, i), "R11", "colOut", colOut, expCol(8'h9A, 8, 0, i));
      check(lastBeat == (i == 7), "R11", "lastBeat", lastBeat, int'(i == 7));
    end
    @(posedge clk); #1;
    check(colValid == 1'b0, "R11", "colValid", colValid, 0);
    checkMode("R11");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [11:0] op;
      logic [1:0]  sel;
      op = 12'($urandom);
      if ($urandom % 4 != 0) begin
        op[2:0] = 3'(1 + $urandom % 3);
        op[6:4] = ($urandom % 2) ? 3'b011 : 3'b100;
      end
      sel = 2'($urandom);
      doLoad(op, sel, "R2");
      doBurst(8'($urandom), mIlv ? "R8" : "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule